// File: doc/BRIEF.md
# Operator Console Sequencer with Boot ROM Overlay

This block sits between the operator console of a 16-bit, word-addressed minicomputer and its CPU. It receives debounced pushbutton levels for run, store, halt and bootstrap, a 16-bit bank of data switches, and a key-lock position. From these it produces a program-counter load strobe with its value, a run/halt control for the CPU and a single-word memory write port. A bootstrap press lays a 32-word boot ROM over the bottom 32 words of memory, loads the program counter with zero and starts the CPU, all as one action.

While the overlay is active, the block steers CPU reads of words 0 to 31 to the ROM and all other reads to RAM. CPU writes are never intercepted, so they always reach RAM. The overlay stays in place until the CPU pulses a dedicated disable strobe, or until the operator performs a run or store action. A halt request takes effect at the next instruction boundary, which the CPU reports with a completion strobe. Turning the key to the locked position disables the pushbuttons and raises an auto-restart enable for power-failure recovery.

Top module: `console_ctrl`

## Requirements
- R1: After synchronous active-high reset, cpu_run, ovl_active, pc_load_en, mem_wr_en and auto_restart_en are 0, and pc_load_val is 0.
- R2: A button counts as pressed in the first cycle its level is sampled high after having been low. When the run button is pressed while the CPU is halted and the key is unlocked, the next cycle shows pc_load_en high with pc_load_val equal to sw_data[14:0], and cpu_run goes high in that same cycle.
- R3: When the store button is pressed while halted and unlocked, the next cycle shows one mem_wr_en pulse with mem_wr_addr equal to cpu_pc and mem_wr_data equal to sw_data. cpu_run stays 0.
- R4: When the bootstrap button is pressed while halted and unlocked, the next cycle shows ovl_active at 1, a pc_load_en pulse with pc_load_val 0, and cpu_run at 1.
- R5: Each accepted action gives exactly one single-cycle pulse on pc_load_en or mem_wr_en, however long the button is held. A further action needs the button to be released and pressed again.
- R6: Run, store and bootstrap presses are ignored while the CPU is running or stopping. The halt button is ignored while the CPU is halted.
- R7: After an accepted halt press, cpu_run stays 1 until insn_done is sampled high. It drops in the cycle after that. An insn_done sampled in the same cycle as the halt press counts. An insn_done while running with no halt pending has no effect.
- R8: While ovl_active is 1 and cpu_rd_addr < 32, cpu_rd_data is combinationally the ROM word at index i = cpu_rd_addr, with value 16'hC000 + i*16'h0111. In every other case, cpu_rd_data equals ram_rd_data.
- R9: A high ovl_off in one cycle makes ovl_active 0 in the next. An accepted run or store action also clears ovl_active. If a bootstrap action and ovl_off fall in the same cycle, the bootstrap action wins and ovl_active becomes 1.
- R10: auto_restart_en follows key_lock with one cycle of delay. Every button press sampled while key_lock is 1 is ignored, including the halt button.
- R11: If several buttons are pressed in the same halted cycle, bootstrap takes priority over run, and run takes priority over store. Only the winner takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_run | input | 1 | Debounced run button level |
| btn_store | input | 1 | Debounced store button level |
| btn_halt | input | 1 | Debounced halt button level |
| btn_boot | input | 1 | Debounced bootstrap button level |
| key_lock | input | 1 | Key in locked position |
| sw_data | input | 16 | Data switch bank |
| cpu_pc | input | 15 | Current program counter from the CPU |
| insn_done | input | 1 | Instruction boundary strobe from the CPU |
| ovl_off | input | 1 | CPU strobe that removes the ROM overlay |
| cpu_rd_addr | input | 15 | CPU read address |
| ram_rd_data | input | 16 | Read data returned by RAM |
| cpu_rd_data | output | 16 | Read data delivered to the CPU |
| pc_load_en | output | 1 | Single-cycle program-counter load strobe |
| pc_load_val | output | 15 | Value to load into the program counter |
| cpu_run | output | 1 | Run (1) or halt (0) control to the CPU |
| mem_wr_en | output | 1 | Single-cycle console memory write strobe |
| mem_wr_addr | output | 15 | Console write address |
| mem_wr_data | output | 16 | Console write data |
| ovl_active | output | 1 | Boot ROM overlay is mapped |
| auto_restart_en | output | 1 | Power-failure auto-restart enable |

## Verification
Two pairs of events can arrive in the same cycle. The first pair is a halt press and the CPU's instruction-completion strobe. The bench drives both on the same cycle and expects cpu_run to fall one cycle later, with no extra cycle spent in the stopping state. The second pair is a bootstrap press and the CPU's overlay-disable strobe. The bench drives both together from the halted state and expects the overlay to be mapped in the next cycle, confirmed by reading a ROM address through the read port.

// File: rtl/console_pkg.sv
package console_pkg;
    localparam int WORD_W    = 16;
    localparam int ADDR_W    = 15;
    localparam int ROM_WORDS = 32;
    localparam int ROM_AW    = $clog2(ROM_WORDS);
    localparam int N_BTN     = 4;

    typedef enum logic [1:0] {
        ST_HALT     = 2'd0,
        ST_RUN      = 2'd1,
        ST_STOPPING = 2'd2
    } run_state_e;

    typedef struct packed {
        logic boot;
        logic run;
        logic store;
        logic halt;
    } btn_s;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } wr_req_s;

    function automatic logic [WORD_W-1:0] boot_word(input logic [ROM_AW-1:0] idx);
        logic [WORD_W-1:0] base;
        logic [WORD_W-1:0] step;
        base = 16'hC000;
        step = 16'h0111;
        return base + WORD_W'(idx) * step;
    endfunction
endpackage

// File: rtl/btn_edge.sv
module btn_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        prev_q <= lvl;
    end

    for (genvar g = 0; g < N; g++) begin : g_edge
        assign rise[g] = lvl[g] & ~prev_q[g];
    end
endmodule

// File: rtl/console_fsm.sv
module console_fsm
    import console_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  btn_s          press,
    input  logic          key_lock,
    input  logic [DW-1:0] sw_data,
    input  logic [AW-1:0] cpu_pc,
    input  logic          insn_done,
    output logic          pc_load_en,
    output logic [AW-1:0] pc_load_val,
    output logic          cpu_run,
    output wr_req_s       wr_req,
    output logic          ovl_set,
    output logic          ovl_clr,
    output logic          auto_restart_en
);
    run_state_e state_q, state_d;
    btn_s       acc;
    logic       halted;

    assign halted = (state_q == ST_HALT);

    always_comb begin
        acc       = '0;
        if (!key_lock) begin
            if (halted) begin
                if (press.boot)       acc.boot  = 1'b1;
                else if (press.run)   acc.run   = 1'b1;
                else if (press.store) acc.store = 1'b1;
            end else if (state_q == ST_RUN) begin
                acc.halt = press.halt;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:     if (acc.boot || acc.run) state_d = ST_RUN;
            ST_RUN:      if (acc.halt) state_d = insn_done ? ST_HALT : ST_STOPPING;
            ST_STOPPING: if (insn_done) state_d = ST_HALT;
            default:     state_d = ST_HALT;
        endcase
    end

    assign ovl_set = acc.boot;
    assign ovl_clr = acc.run | acc.store;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q         <= ST_HALT;
            pc_load_en      <= 1'b0;
            pc_load_val     <= '0;
            wr_req          <= '0;
            auto_restart_en <= 1'b0;
        end else begin
            state_q         <= state_d;
            pc_load_en      <= acc.boot | acc.run;
            auto_restart_en <= key_lock;
            if (acc.boot)     pc_load_val <= '0;
            else if (acc.run) pc_load_val <= sw_data[AW-1:0];
            wr_req.en <= acc.store;
            if (acc.store) begin
                wr_req.addr <= cpu_pc;
                wr_req.data <= sw_data;
            end
        end
    end

    assign cpu_run = (state_q != ST_HALT);
endmodule

// File: rtl/boot_overlay.sv
module boot_overlay
    import console_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int DW    = WORD_W,
    parameter int DEPTH = ROM_WORDS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ovl_set,
    input  logic          ovl_clr,
    input  logic          ovl_off,
    input  logic [AW-1:0] cpu_rd_addr,
    input  logic [DW-1:0] ram_rd_data,
    output logic [DW-1:0] cpu_rd_data,
    output logic          ovl_active
);
    localparam int IW = $clog2(DEPTH);

    logic [DW-1:0] rom [DEPTH];
    logic          in_window;

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = boot_word(IW'(g));
    end

    always_ff @(posedge clk) begin
        if (rst)                      ovl_active <= 1'b0;
        else if (ovl_set)             ovl_active <= 1'b1;
        else if (ovl_clr || ovl_off)  ovl_active <= 1'b0;
    end

    assign in_window   = (cpu_rd_addr < AW'(DEPTH));
    assign cpu_rd_data = (ovl_active && in_window) ? rom[cpu_rd_addr[IW-1:0]] : ram_rd_data;
endmodule

// File: rtl/console_ctrl.sv
module console_ctrl
    import console_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          btn_run,
    input  logic          btn_store,
    input  logic          btn_halt,
    input  logic          btn_boot,
    input  logic          key_lock,
    input  logic [DW-1:0] sw_data,
    input  logic [AW-1:0] cpu_pc,
    input  logic          insn_done,
    input  logic          ovl_off,
    input  logic [AW-1:0] cpu_rd_addr,
    input  logic [DW-1:0] ram_rd_data,
    output logic [DW-1:0] cpu_rd_data,
    output logic          pc_load_en,
    output logic [AW-1:0] pc_load_val,
    output logic          cpu_run,
    output logic          mem_wr_en,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data,
    output logic          ovl_active,
    output logic          auto_restart_en
);
    btn_s    lvl, press;
    wr_req_s wr_req;
    logic    ovl_set, ovl_clr;

    assign lvl = '{boot: btn_boot, run: btn_run, store: btn_store, halt: btn_halt};

    btn_edge #(.N(N_BTN)) u_edge (
        .clk  (clk),
        .lvl  (lvl),
        .rise (press)
    );

    console_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk             (clk),
        .rst             (rst),
        .press           (press),
        .key_lock        (key_lock),
        .sw_data         (sw_data),
        .cpu_pc          (cpu_pc),
        .insn_done       (insn_done),
        .pc_load_en      (pc_load_en),
        .pc_load_val     (pc_load_val),
        .cpu_run         (cpu_run),
        .wr_req          (wr_req),
        .ovl_set         (ovl_set),
        .ovl_clr         (ovl_clr),
        .auto_restart_en (auto_restart_en)
    );

    boot_overlay #(.AW(AW), .DW(DW), .DEPTH(ROM_WORDS)) u_ovl (
        .clk         (clk),
        .rst         (rst),
        .ovl_set     (ovl_set),
        .ovl_clr     (ovl_clr),
        .ovl_off     (ovl_off),
        .cpu_rd_addr (cpu_rd_addr),
        .ram_rd_data (ram_rd_data),
        .cpu_rd_data (cpu_rd_data),
        .ovl_active  (ovl_active)
    );

    assign mem_wr_en   = wr_req.en;
    assign mem_wr_addr = wr_req.addr;
    assign mem_wr_data = wr_req.data;
endmodule

// File: rtl/console_ctrl_chk.sv
module console_ctrl_chk #(
    parameter int AW = 15,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          key_lock,
    input logic          insn_done,
    input logic          ovl_off,
    input logic [AW-1:0] cpu_rd_addr,
    input logic [DW-1:0] ram_rd_data,
    input logic [DW-1:0] cpu_rd_data,
    input logic          pc_load_en,
    input logic [AW-1:0] pc_load_val,
    input logic          cpu_run,
    input logic          mem_wr_en,
    input logic          ovl_active,
    input logic          auto_restart_en
);
    AST_PCLOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        pc_load_en |=> !pc_load_en); // R5
    AST_WRITE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |=> !mem_wr_en); // R5
    AST_PCLOAD_STARTS_CPU: assert property (@(posedge clk) disable iff (rst)
        pc_load_en |-> cpu_run); // R2
    AST_WRITE_WHILE_HALTED: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> !cpu_run); // R3
    AST_OVL_RISE_LOADS_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(ovl_active) |-> (pc_load_en && pc_load_val == '0)); // R4
    AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        key_lock |=> (!pc_load_en && !mem_wr_en)); // R10
    AST_RESTART_FOLLOWS_KEY: assert property (@(posedge clk) disable iff (rst)
        key_lock |=> auto_restart_en); // R10
    AST_HALT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_run) |-> $past(insn_done)); // R7
    AST_RAM_WHEN_NO_OVL: assert property (@(posedge clk) disable iff (rst)
        !ovl_active |-> (cpu_rd_data == ram_rd_data)); // R8
    AST_RAM_OUTSIDE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd_addr >= AW'(32)) |-> (cpu_rd_data == ram_rd_data)); // R8
    AST_OVL_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ovl_off && !pc_load_en && !cpu_run && ovl_active && !mem_wr_en && key_lock) |=> !ovl_active); // R9
endmodule

bind console_ctrl console_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .key_lock        (key_lock),
    .insn_done       (insn_done),
    .ovl_off         (ovl_off),
    .cpu_rd_addr     (cpu_rd_addr),
    .ram_rd_data     (ram_rd_data),
    .cpu_rd_data     (cpu_rd_data),
    .pc_load_en      (pc_load_en),
    .pc_load_val     (pc_load_val),
    .cpu_run         (cpu_run),
    .mem_wr_en       (mem_wr_en),
    .ovl_active      (ovl_active),
    .auto_restart_en (auto_restart_en)
);

// File: tb/console_ctrl_tb_top.sv
module console_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        btn_run = 0, btn_store = 0, btn_halt = 0, btn_boot = 0;
    logic        key_lock = 0, insn_done = 0, ovl_off = 0;
    logic [15:0] sw_data = '0;
    logic [14:0] cpu_pc = '0;
    logic [14:0] cpu_rd_addr = '0;
    logic [15:0] ram_rd_data = 16'h5A5A;
    logic [15:0] cpu_rd_data;
    logic        pc_load_en, cpu_run, mem_wr_en, ovl_active, auto_restart_en;
    logic [14:0] pc_load_val, mem_wr_addr;
    logic [15:0] mem_wr_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    console_ctrl dut_i (
        .clk(clk), .rst(rst),
        .btn_run(btn_run), .btn_store(btn_store), .btn_halt(btn_halt), .btn_boot(btn_boot),
        .key_lock(key_lock), .sw_data(sw_data), .cpu_pc(cpu_pc),
        .insn_done(insn_done), .ovl_off(ovl_off),
        .cpu_rd_addr(cpu_rd_addr), .ram_rd_data(ram_rd_data), .cpu_rd_data(cpu_rd_data),
        .pc_load_en(pc_load_en), .pc_load_val(pc_load_val), .cpu_run(cpu_run),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .ovl_active(ovl_active), .auto_restart_en(auto_restart_en)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] rom_exp(input int i);
        return 16'(16'hC000 + i * 16'h0111);
    endfunction

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic release_all();
        btn_run = 0; btn_store = 0; btn_halt = 0; btn_boot = 0;
        tick();
    endtask

    task automatic stop_cpu();
        btn_halt = 1; insn_done = 1;
        tick();
        btn_halt = 0; insn_done = 0;
        tick();
    endtask

    task automatic t_reset();
        rst = 1; tick(2); rst = 0;
        chk("R1", "cpu_run", cpu_run, 0);
        chk("R1", "ovl_active", ovl_active, 0);
        chk("R1", "pc_load_val", pc_load_val, 0);
        chk("R1", "pulses", {pc_load_en, mem_wr_en}, 0);
        chk("R1", "auto_restart_en", auto_restart_en, 0);
    endtask

    task automatic t_store();
        cpu_pc = 15'h0123; sw_data = 16'hBEEF; btn_store = 1;
        tick();
        chk("R3", "wr_en", mem_wr_en, 1);
        chk("R3", "wr_addr", mem_wr_addr, 15'h0123);
        chk("R3", "wr_data", mem_wr_data, 16'hBEEF);
        chk("R3", "run", cpu_run, 0);
        tick(3);
        chk("R5", "wr_en held", mem_wr_en, 0);
        release_all();
        btn_store = 1; tick();
        chk("R5", "re-press writes", mem_wr_en, 1);
        release_all();
    endtask

    task automatic t_run();
        sw_data = 16'hF234; btn_run = 1;
        tick();
        chk("R2", "pc_load_en", pc_load_en, 1);
        chk("R2", "pc_load_val", pc_load_val, 15'h7234);
        chk("R2", "run", cpu_run, 1);
        tick();
        chk("R5", "pc_load_en one cycle", pc_load_en, 0);
        release_all();
        btn_run = 1; btn_store = 1; btn_boot = 1; tick();
        chk("R6", "no action while running", {pc_load_en, mem_wr_en, ovl_active}, 0);
        release_all();
        insn_done = 1; tick(); insn_done = 0;
        chk("R7", "done without halt keeps run", cpu_run, 1);
    endtask

    task automatic t_halt();
        btn_halt = 1; tick(); btn_halt = 0;
        chk("R7", "run held while stopping", cpu_run, 1);
        tick(3);
        chk("R7", "run held awaiting boundary", cpu_run, 1);
        insn_done = 1; tick(); insn_done = 0;
        chk("R7", "run dropped after boundary", cpu_run, 0);
        btn_halt = 1; tick(); btn_halt = 0;
        chk("R6", "halt ignored while halted", cpu_run, 0);
        tick();
        btn_run = 1; tick(); release_all();
        btn_halt = 1; insn_done = 1; tick(); btn_halt = 0; insn_done = 0;
        chk("R7", "same-cycle halt and boundary", cpu_run, 0);
    endtask

    task automatic t_boot();
        ram_rd_data = 16'h1111;
        btn_boot = 1; tick();
        chk("R4", "ovl_active", ovl_active, 1);
        chk("R4", "pc_load", {pc_load_en, 1'b0, pc_load_val}, {1'b1, 1'b0, 15'h0});
        chk("R4", "run", cpu_run, 1);
        release_all();
        cpu_rd_addr = 15'd0;  #1 chk("R8", "rom[0]", cpu_rd_data, rom_exp(0));
        cpu_rd_addr = 15'd31; #1 chk("R8", "rom[31]", cpu_rd_data, rom_exp(31));
        cpu_rd_addr = 15'd32; #1 chk("R8", "addr 32 from ram", cpu_rd_data, 16'h1111);
        cpu_rd_addr = 15'd7;
        ovl_off = 1; tick(); ovl_off = 0;
        chk("R9", "ovl_off clears", ovl_active, 0);
        chk("R8", "addr 7 from ram", cpu_rd_data, 16'h1111);
        stop_cpu();
        btn_boot = 1; ovl_off = 1; tick(); ovl_off = 0;
        chk("R9", "boot beats ovl_off", ovl_active, 1);
        chk("R8", "rom[7]", cpu_rd_data, rom_exp(7));
        release_all();
        stop_cpu();
        btn_store = 1; tick();
        chk("R9", "store clears overlay", ovl_active, 0);
        release_all();
    endtask

    task automatic t_priority();
        btn_run = 1; btn_store = 1; btn_boot = 1; sw_data = 16'h0F0F;
        tick();
        chk("R11", "boot wins pc value", pc_load_val, 0);
        chk("R11", "boot wins overlay", ovl_active, 1);
        chk("R11", "no write", mem_wr_en, 0);
        release_all();
        stop_cpu();
        btn_run = 1; btn_store = 1; tick();
        chk("R11", "run over store", {pc_load_en, mem_wr_en}, 2'b10);
        chk("R9", "run clears overlay", ovl_active, 0);
        release_all();
        stop_cpu();
    endtask

    task automatic t_lock();
        key_lock = 1; tick();
        chk("R10", "auto restart on", auto_restart_en, 1);
        btn_run = 1; tick();
        chk("R10", "run ignored locked", {pc_load_en, cpu_run}, 0);
        release_all();
        btn_store = 1; tick();
        chk("R10", "store ignored locked", mem_wr_en, 0);
        release_all();
        key_lock = 0; tick();
        chk("R10", "auto restart off", auto_restart_en, 0);
        btn_run = 1; tick(); release_all();
        key_lock = 1; btn_halt = 1; insn_done = 1; tick();
        btn_halt = 0; insn_done = 0; tick();
        chk("R10", "halt ignored locked", cpu_run, 1);
        key_lock = 0; tick();
        stop_cpu();
        chk("R7", "halted after unlock", cpu_run, 0);
    endtask

    initial begin
        fork
            begin
                tick();
                t_reset();
                t_store();
                t_run();
                t_halt();
                t_boot();
                t_priority();
                t_lock();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule